// File: doc/BRIEF.md
# Lockstep Pin Comparator

This block sits beside one bus-interface node of a duplicated pair. Both nodes compute the same outputs from the same inputs. Only the node acting as master drives the shared pins. The node acting as checker keeps its drivers off. It compares what it computed internally against what it sees on the pins, and it flags any bit that differs.

The role is captured from a configuration bit when the initialization strobe fires. A diagnostic control inverts that role while the system runs. A software bit can stop the comparison of the bus fields, and a software bit clears the sticky error flag. Each received word is held back for a fixed window so that a late error can still disqualify it before the word reaches permanent state.

The request line is compared on every cycle. The 16-bit data bus, the 3-bit control field and the 2-bit check field are compared only in cycles where this node holds the bus grant.

Top module: `mc_compare`

## Requirements
- R1: While reset is asserted and until the first initialization strobe, `mis_err`, `mis_sticky`, `data_ok`, `drv_en_req` and `drv_en_bus` are all 0.
- R2: When `init_stb` is high at a clock edge, `init_role` is captured as the role (1 = master, 0 = checker). As master with no flip, `drv_en_req` is 1 and `drv_en_bus` equals `int_grant`.
- R3: While the effective role is checker, `drv_en_req` and `drv_en_bus` are both 0.
- R4: In checker mode, a difference between `int_req` and `pin_req` in a cycle sets `mis_err` for exactly the following cycle, whatever the value of `int_grant`. Each mismatching cycle gives one high cycle of `mis_err`.
- R5: The data, control and check fields are compared only when `int_grant` is 1. A difference in those fields while `int_grant` is 0 leaves `mis_err` at 0.
- R6: While `sw_bus_chk_off` is 1, differences in the data, control and check fields are ignored, but the request line is still compared.
- R7: While the effective role is master, no pin difference raises `mis_err`.
- R8: The effective role is the captured role inverted whenever `sw_role_flip` is 1. A master flipped to checker stops driving and flags a mismatch against the undriven (low) pins.
- R9: `mis_sticky` goes high together with `mis_err` and stays high until `sw_sticky_clr` is seen with no new mismatch in the same cycle. A new mismatch wins over a clear.
- R10: A word marked by `rx_word_vld` at a clock edge raises `data_ok` for one cycle after the third edge, counting the capture edge. A mismatch detected at any of those three edges suppresses that word's `data_ok`.
- R11: No comparison takes place after reset until `init_stb` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_stb | input | 1 | Initialization strobe; captures the role and arms comparison |
| init_role | input | 1 | Role at initialization: 1 master, 0 checker |
| sw_role_flip | input | 1 | Diagnostic role inversion |
| sw_bus_chk_off | input | 1 | Disables comparison of data, control and check fields |
| sw_sticky_clr | input | 1 | Clears the sticky error flag |
| int_grant | input | 1 | This node currently owns the memory bus |
| int_req | input | 1 | Internally computed request |
| int_data | input | 16 | Internally computed data/address |
| int_ctl | input | 3 | Internally computed control field |
| int_chk | input | 2 | Internally computed check field |
| pin_req | input | 1 | Request seen on the shared pin |
| pin_data | input | 16 | Data/address seen on the shared pins |
| pin_ctl | input | 3 | Control field seen on the shared pins |
| pin_chk | input | 2 | Check field seen on the shared pins |
| rx_word_vld | input | 1 | A received word is present this cycle |
| drv_en_req | output | 1 | Output enable for the request pin |
| drv_en_bus | output | 1 | Output enable for the bus, control and check pins |
| mis_err | output | 1 | One-cycle mismatch pulse |
| mis_sticky | output | 1 | Sticky mismatch flag |
| data_ok | output | 1 | Held-back received word is now safe to use |

## Verification
The drive enables follow the role and grant combinationally, so the bench checks them one nanosecond after it changes the inputs. `mis_err` and `mis_sticky` are registered from the compare made on the preceding edge. Mismatches are therefore set up at a falling edge and read at the next falling edge. `data_ok` is due after the third rising edge counted from the capture edge. The bench reads it at the falling edges after the second, third and fourth edges so that both early and late pulses show up. A mismatch is injected inside the window to show that the word is dropped.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  typedef enum logic {
    ROLE_CHECKER = 1'b0,
    ROLE_MASTER  = 1'b1
  } role_e;
endpackage

// File: rtl/mc_role.sv
`timescale 1ns/1ps
module mc_role
  import mc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_stb,
  input  logic init_role,
  input  logic sw_role_flip,
  output logic is_master,
  output logic armed
);
  role_e role_q, role_d;
  logic  armed_q, armed_d;

  always_comb begin
    role_d  = role_q;
    armed_d = armed_q;
    if (init_stb) begin
      role_d  = init_role ? ROLE_MASTER : ROLE_CHECKER;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q  <= ROLE_CHECKER;
      armed_q <= 1'b0;
    end else begin
      role_q  <= role_d;
      armed_q <= armed_d;
    end
  end

  assign is_master = (role_q == ROLE_MASTER) ^ sw_role_flip;
  assign armed     = armed_q;
endmodule

// File: rtl/mc_cmp.sv
`timescale 1ns/1ps
module mc_cmp #(
  parameter int DATA_W = 16,
  parameter int CTL_W  = 3,
  parameter int CHK_W  = 2
) (
  input  logic              is_master,
  input  logic              armed,
  input  logic              grant,
  input  logic              bus_off,
  input  logic              int_req,
  input  logic [DATA_W-1:0] int_data,
  input  logic [CTL_W-1:0]  int_ctl,
  input  logic [CHK_W-1:0]  int_chk,
  input  logic              pin_req,
  input  logic [DATA_W-1:0] pin_data,
  input  logic [CTL_W-1:0]  pin_ctl,
  input  logic [CHK_W-1:0]  pin_chk,
  output logic              mismatch
);
  localparam int BUS_W = DATA_W + CTL_W + CHK_W;

  logic [BUS_W-1:0] own_vec, seen_vec, diff_vec;
  logic             req_diff, bus_diff, bus_gate;

  assign own_vec  = {int_data, int_ctl, int_chk};
  assign seen_vec = {pin_data, pin_ctl, pin_chk};

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    assign diff_vec[b] = own_vec[b] ^ seen_vec[b];
  end

  always_comb begin
    req_diff = int_req ^ pin_req;
    bus_gate = grant & ~bus_off;
    bus_diff = bus_gate & (|diff_vec);
    mismatch = armed & ~is_master & (req_diff | bus_diff);
  end
endmodule

// File: rtl/mc_hold.sv
`timescale 1ns/1ps
module mc_hold #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld,
  input  logic kill,
  output logic data_ok
);
  logic [HOLD_CYC-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = rx_vld & ~kill;
    for (int i = 1; i < HOLD_CYC; i++) begin
      stg_d[i] = stg_q[i-1] & ~kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign data_ok = stg_q[HOLD_CYC-1];

  // R10
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok |-> $past(!kill));
endmodule

// File: rtl/mc_compare.sv
`timescale 1ns/1ps
module mc_compare #(
  parameter int DATA_W   = 16,
  parameter int CTL_W    = 3,
  parameter int CHK_W    = 2,
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_stb,
  input  logic              init_role,
  input  logic              sw_role_flip,
  input  logic              sw_bus_chk_off,
  input  logic              sw_sticky_clr,
  input  logic              int_grant,
  input  logic              int_req,
  input  logic [DATA_W-1:0] int_data,
  input  logic [CTL_W-1:0]  int_ctl,
  input  logic [CHK_W-1:0]  int_chk,
  input  logic              pin_req,
  input  logic [DATA_W-1:0] pin_data,
  input  logic [CTL_W-1:0]  pin_ctl,
  input  logic [CHK_W-1:0]  pin_chk,
  input  logic              rx_word_vld,
  output logic              drv_en_req,
  output logic              drv_en_bus,
  output logic              mis_err,
  output logic              mis_sticky,
  output logic              data_ok
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       is_master, armed, mismatch;
  logic       err_d, sticky_d;
  logic       err_q, sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  mc_role i_role (
    .clk          (clk),
    .rst_n        (rst_s),
    .init_stb     (init_stb),
    .init_role    (init_role),
    .sw_role_flip (sw_role_flip),
    .is_master    (is_master),
    .armed        (armed)
  );

  mc_cmp #(.DATA_W(DATA_W), .CTL_W(CTL_W), .CHK_W(CHK_W)) i_cmp (
    .is_master (is_master),
    .armed     (armed),
    .grant     (int_grant),
    .bus_off   (sw_bus_chk_off),
    .int_req   (int_req),
    .int_data  (int_data),
    .int_ctl   (int_ctl),
    .int_chk   (int_chk),
    .pin_req   (pin_req),
    .pin_data  (pin_data),
    .pin_ctl   (pin_ctl),
    .pin_chk   (pin_chk),
    .mismatch  (mismatch)
  );

  mc_hold #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk     (clk),
    .rst_n   (rst_s),
    .rx_vld  (rx_word_vld),
    .kill    (mismatch),
    .data_ok (data_ok)
  );

  always_comb begin
    err_d    = mismatch;
    sticky_d = sticky_q;
    if (sw_sticky_clr) sticky_d = 1'b0;
    if (mismatch)      sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      sticky_q <= sticky_d;
    end
  end

  assign mis_err    = err_q;
  assign mis_sticky = sticky_q;
  assign drv_en_req = is_master;
  assign drv_en_bus = is_master & int_grant;

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mis_err |-> mis_sticky);
  // R7
  master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(drv_en_req) |-> !mis_err);
  // R5
  nogrant_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(!int_grant && (int_req == pin_req)) |-> !mis_err);
  // R11
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $past(!armed) |-> !mis_err);
  // R3
  nodrive_chk: assert property (@(posedge clk) disable iff (!rst_s)
    drv_en_bus |-> drv_en_req);
endmodule

// File: tb/test_mc_compare.sv
`timescale 1ns/1ps
module test_mc_compare;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_stb, init_role, sw_role_flip, sw_bus_chk_off, sw_sticky_clr;
  logic        int_grant, int_req, pin_req, rx_word_vld;
  logic [15:0] int_data, pin_data;
  logic [2:0]  int_ctl, pin_ctl;
  logic [1:0]  int_chk, pin_chk;
  logic        drv_en_req, drv_en_bus, mis_err, mis_sticky, data_ok;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mc_compare i_mc_compare (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .init_role(init_role),
    .sw_role_flip(sw_role_flip), .sw_bus_chk_off(sw_bus_chk_off),
    .sw_sticky_clr(sw_sticky_clr), .int_grant(int_grant), .int_req(int_req),
    .int_data(int_data), .int_ctl(int_ctl), .int_chk(int_chk),
    .pin_req(pin_req), .pin_data(pin_data), .pin_ctl(pin_ctl),
    .pin_chk(pin_chk), .rx_word_vld(rx_word_vld), .drv_en_req(drv_en_req),
    .drv_en_bus(drv_en_bus), .mis_err(mis_err), .mis_sticky(mis_sticky),
    .data_ok(data_ok)
  );

  // row: {grant, bus_off, int_req, pin_req, int_data, pin_data, exp_err}
  localparam int NROW = 8;
  localparam logic [36:0] VEC [NROW] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hA5A5, 16'hA5A5, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hA5A5, 16'hA5A4, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h4321, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h0000, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F, 16'h0F0F, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    int_grant = 0; int_req = 0; pin_req = 0;
    int_data = 16'h0; pin_data = 16'h0;
    int_ctl = 3'h0; pin_ctl = 3'h0; int_chk = 2'h0; pin_chk = 2'h0;
    rx_word_vld = 0; sw_sticky_clr = 0; sw_bus_chk_off = 0; init_stb = 0;
  endtask

  task automatic do_reset();
    quiet();
    sw_role_flip = 0; init_role = 0;
    rst_n = 0;
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic do_init(input logic role);
    init_role = role; init_stb = 1;
    tick();
    init_stb = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    quiet();
    sw_role_flip = 0; init_role = 0;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 err in reset", mis_err, 0);
    chk("R1 sticky in reset", mis_sticky, 0);
    chk("R1 data_ok in reset", data_ok, 0);
    chk("R1 drv_en_req in reset", drv_en_req, 0);
    chk("R1 drv_en_bus in reset", drv_en_bus, 0);
    rst_n = 1;
    repeat (3) tick();

    // R11: no compare before init
    int_req = 1; int_grant = 1; int_data = 16'hFFFF;
    tick();
    chk("R11 unarmed err", mis_err, 0);
    chk("R11 unarmed sticky", mis_sticky, 0);
    quiet();

    // R2 / R7: master
    do_init(1'b1);
    int_grant = 0; #1;
    chk("R2 master req enable", drv_en_req, 1);
    chk("R2 master bus enable no grant", drv_en_bus, 0);
    int_grant = 1; #1;
    chk("R2 master bus enable grant", drv_en_bus, 1);
    int_req = 1; int_data = 16'h00FF; int_ctl = 3'h5;
    tick();
    chk("R7 master ignores mismatch", mis_err, 0);
    quiet();

    // R8: master flipped to checker, partner also checker, pins low
    sw_role_flip = 1; #1;
    chk("R8 flipped req enable", drv_en_req, 0);
    int_grant = 1; int_req = 1; int_data = 16'h0042;
    tick();
    chk("R8 both checkers mismatch", mis_err, 1);
    quiet();
    sw_role_flip = 0;

    // Checker mode
    do_reset();
    do_init(1'b0);
    int_grant = 1; #1;
    chk("R3 checker req enable", drv_en_req, 0);
    chk("R3 checker bus enable", drv_en_bus, 0);

    // Table walk: R4 R5 R6
    for (int r = 0; r < NROW; r++) begin
      {int_grant, sw_bus_chk_off, int_req, pin_req, int_data, pin_data} = VEC[r][36:1];
      tick();
      chk($sformatf("R4/R5/R6 row %0d", r), mis_err, VEC[r][0]);
    end
    quiet();
    tick();

    // R5: control and check fields
    int_grant = 1; int_ctl = 3'h4; pin_ctl = 3'h0;
    tick();
    chk("R5 ctl mismatch", mis_err, 1);
    int_ctl = 3'h0; int_chk = 2'h2;
    tick();
    chk("R5 chk mismatch", mis_err, 1);
    int_grant = 0;
    tick();
    chk("R5 chk mismatch no grant", mis_err, 0);
    quiet();

    // R4: one pulse per mismatching cycle
    int_req = 1;
    tick();
    chk("R4 pulse 1", mis_err, 1);
    tick();
    chk("R4 pulse 2", mis_err, 1);
    int_req = 0;
    tick();
    chk("R4 pulse ends", mis_err, 0);

    // R9: sticky
    chk("R9 sticky held", mis_sticky, 1);
    sw_sticky_clr = 1;
    tick();
    chk("R9 sticky cleared", mis_sticky, 0);
    int_req = 1;
    tick();
    chk("R9 set beats clear", mis_sticky, 1);
    quiet();
    tick();
    chk("R9 sticky holds without clear", mis_sticky, 1);

    // R10: hold window
    rx_word_vld = 1;
    tick();
    rx_word_vld = 0;
    tick();
    chk("R10 not early", data_ok, 0);
    tick();
    chk("R10 due", data_ok, 1);
    tick();
    chk("R10 single cycle", data_ok, 0);

    rx_word_vld = 1;
    tick();
    rx_word_vld = 0; int_req = 1;
    tick();
    int_req = 0;
    tick();
    chk("R10 killed word", data_ok, 0);
    tick();
    chk("R10 killed word later", data_ok, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule